// File: doc/BRIEF.md
# Power Domain Switch Sequencer

This block turns one gated power domain on or off when asked. It owns the domain's control word, which holds a reset-release bit, an isolation bit, two supply-enable bits (primary and secondary), a clock-disable bit and a group of SRAM power-down bits. It moves the word one step per clock in a fixed order. Between steps it waits for handshakes: two supply status acknowledges, per-bank SRAM power-down acknowledges and, optionally, a bus-protection acknowledge.

A requester raises `req_valid` for one cycle with `req_on` giving the wanted state. The sequencer reports `done` when the order completes. If a wait runs past its cycle budget, it reports `tmo` and a sticky `err`. A request for the state the domain is already in completes at once. Parameters set the SRAM field width, the acknowledge width and mask, whether bus protection is present, and the wait budget.

Top module: `pwr_domain_seq`

## Requirements
- R1: After reset the control word is the off pattern. Bit 0 (reset release), bit 2 (primary supply) and bit 3 (secondary supply) are 0. Bit 1 (isolation), bit 4 (clock disable) and every SRAM power-down bit from bit 8 upward are 1; bits 5 to 7 are 0 (0xF12 by default). `bp_req` is 1 when bus protection is present. `done`, `tmo`, `err` and `busy` are 0.
- R2: A power-up sets the primary supply bit first, and sets the secondary supply bit one cycle later in a separate step.
- R3: The domain counts as on only when both status acknowledges are 1, and as off only when both are 0. While exactly one is 1, the sequencer keeps waiting and changes nothing.
- R4: Once both acknowledges read 1, power-up continues one change per cycle: clear clock disable, then clear isolation, then set reset release, then clear all SRAM power-down bits.
- R5: After the SRAM bits are cleared, power-up waits until every acknowledge bit selected by the mask reads 0. With an empty mask this wait is skipped.
- R6: With bus protection present, `bp_req` drops only after the SRAM wake has finished, and power-up then waits for `bp_ack` to read 0.
- R7: Power-down first raises `bp_req` and waits for `bp_ack` to read 1 (when bus protection is present). It then sets every SRAM power-down bit and waits until every masked acknowledge bit reads 1, skipping that wait with an empty mask.
- R8: Power-down continues one change per cycle: set isolation, clear reset release, set clock disable, clear primary supply, clear secondary supply. It then waits until both status acknowledges read 0 and reports `done`.
- R9: Each wait is bounded by `TMO_CYCLES` cycles. On expiry the sequencer pulses `tmo` for one cycle, sets `err`, gives no `done`, leaves the control word and `bp_req` as they stand, and returns to idle without changing its recorded domain state.
- R10: `err` stays set until the next accepted request, which clears it.
- R11: A request that arrives while `busy` is 1 is ignored.
- R12: A request for the recorded domain state raises `done` in the cycle after the request, with no change to the control word.
- R13: `done` is a one-cycle pulse raised only while `busy` is 0, in the cycle after the final wait is satisfied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, sampled only when idle |
| req_on | input | 1 | Requested state: 1 on, 0 off |
| stat_ack_a | input | 1 | First supply status acknowledge |
| stat_ack_b | input | 1 | Second supply status acknowledge |
| sram_ack | input | ACK_W | SRAM power-down acknowledges |
| bp_ack | input | 1 | Bus-protection acknowledge |
| ctrl_word | output | SRAM_W+8 | Domain control word |
| bp_req | output | 1 | Bus protection asserted |
| done | output | 1 | Sequence complete pulse |
| err | output | 1 | Sticky error flag |
| tmo | output | 1 | Timeout pulse |
| busy | output | 1 | Sequence running |

## Verification
A wrong internal state shows on the control word within one cycle. Every sequencing state makes exactly one bit change, so a skipped or swapped state shows up as a misordered change in the log of word values. A wait that exits early shows as clock disable falling before both status acknowledges are high, or as `bp_req` dropping while SRAM bits are still set. A wait that never exits shows as `tmo` and `err` after `TMO_CYCLES` cycles instead of `done`. A corrupted record of the domain state shows in the next request: a full sequence runs where an immediate `done` was due, or the reverse.

// File: rtl/pds_pkg.sv
package pds_pkg;

    localparam int BIT_RST  = 0;
    localparam int BIT_ISO  = 1;
    localparam int BIT_PON  = 2;
    localparam int BIT_PON2 = 3;
    localparam int BIT_CKD  = 4;
    localparam int SRAM_LSB = 8;

    typedef enum logic [4:0] {
        ST_IDLE,
        ST_U_PON, ST_U_PON2, ST_U_WSTAT, ST_U_CKEN, ST_U_ISO, ST_U_RST,
        ST_U_SRAM, ST_U_WSRAM, ST_U_BP, ST_U_WBP,
        ST_D_BP, ST_D_WBP, ST_D_SRAM, ST_D_WSRAM, ST_D_ISO, ST_D_RST,
        ST_D_CKD, ST_D_PON, ST_D_PON2, ST_D_WSTAT
    } seq_st_e;

    typedef enum logic [3:0] {
        OP_NONE,
        OP_SET_PON, OP_SET_PON2, OP_CLR_CKD, OP_CLR_ISO, OP_SET_RST, OP_CLR_SRAM,
        OP_SET_SRAM, OP_SET_ISO, OP_CLR_RST, OP_SET_CKD, OP_CLR_PON, OP_CLR_PON2
    } ctrl_op_e;

    function automatic logic is_wait(input seq_st_e s);
        return (s == ST_U_WSTAT) || (s == ST_U_WSRAM) || (s == ST_U_WBP) ||
               (s == ST_D_WBP)   || (s == ST_D_WSRAM) || (s == ST_D_WSTAT);
    endfunction

    function automatic ctrl_op_e op_of(input seq_st_e s);
        case (s)
            ST_U_PON:  return OP_SET_PON;
            ST_U_PON2: return OP_SET_PON2;
            ST_U_CKEN: return OP_CLR_CKD;
            ST_U_ISO:  return OP_CLR_ISO;
            ST_U_RST:  return OP_SET_RST;
            ST_U_SRAM: return OP_CLR_SRAM;
            ST_D_SRAM: return OP_SET_SRAM;
            ST_D_ISO:  return OP_SET_ISO;
            ST_D_RST:  return OP_CLR_RST;
            ST_D_CKD:  return OP_SET_CKD;
            ST_D_PON:  return OP_CLR_PON;
            ST_D_PON2: return OP_CLR_PON2;
            default:   return OP_NONE;
        endcase
    endfunction

endpackage

// File: rtl/pds_ctrl_word.sv
module pds_ctrl_word
    import pds_pkg::*;
#(
    parameter int SRAM_W = 4,
    localparam int CTRL_W = SRAM_LSB + SRAM_W
) (
    input  logic              clk,
    input  logic              rst,
    input  ctrl_op_e          op,
    output logic [CTRL_W-1:0] word
);

    logic [CTRL_W-1:0] sram_mask;
    logic [CTRL_W-1:0] off_word;

    for (genvar g = 0; g < CTRL_W; g++) begin : g_mask
        assign sram_mask[g] = (g >= SRAM_LSB);
    end

    assign off_word = sram_mask | (CTRL_W'(1) << BIT_ISO) | (CTRL_W'(1) << BIT_CKD);

    always_ff @(posedge clk) begin
        if (rst) begin
            word <= off_word;
        end else begin
            case (op)
                OP_SET_PON:  word[BIT_PON]  <= 1'b1;
                OP_SET_PON2: word[BIT_PON2] <= 1'b1;
                OP_CLR_CKD:  word[BIT_CKD]  <= 1'b0;
                OP_CLR_ISO:  word[BIT_ISO]  <= 1'b0;
                OP_SET_RST:  word[BIT_RST]  <= 1'b1;
                OP_CLR_SRAM: word <= word & ~sram_mask;
                OP_SET_SRAM: word <= word | sram_mask;
                OP_SET_ISO:  word[BIT_ISO]  <= 1'b1;
                OP_CLR_RST:  word[BIT_RST]  <= 1'b0;
                OP_SET_CKD:  word[BIT_CKD]  <= 1'b1;
                OP_CLR_PON:  word[BIT_PON]  <= 1'b0;
                OP_CLR_PON2: word[BIT_PON2] <= 1'b0;
                default:     word <= word;
            endcase
        end
    end

endmodule

// File: rtl/pds_timeout.sv
module pds_timeout #(
    parameter int TMO_CYCLES = 64,
    localparam int CW = $clog2(TMO_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expired
);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= CW'(TMO_CYCLES - 1);
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = run && (cnt == '0);

endmodule

// File: rtl/pds_fsm.sv
module pds_fsm
    import pds_pkg::*;
#(
    parameter int              ACK_W    = 4,
    parameter logic [ACK_W-1:0] ACK_MASK = '1,
    parameter bit              USE_BP   = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             req_on,
    input  logic             stat_a,
    input  logic             stat_b,
    input  logic [ACK_W-1:0] sram_ack,
    input  logic             bp_ack,
    input  logic             expired,
    output seq_st_e          st,
    output logic             bp_req,
    output logic             done,
    output logic             tmo,
    output logic             err,
    output logic             busy
);

    localparam bit HAS_SRAM_WAIT = (ACK_MASK != '0);

    logic dom_on;
    logic sram_all_low;
    logic sram_all_high;

    assign sram_all_low  = ((sram_ack & ACK_MASK) == '0);
    assign sram_all_high = ((sram_ack & ACK_MASK) == ACK_MASK);
    assign busy          = (st != ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            dom_on <= 1'b0;
            bp_req <= USE_BP;
            done   <= 1'b0;
            tmo    <= 1'b0;
            err    <= 1'b0;
        end else begin
            done <= 1'b0;
            tmo  <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (req_valid) begin
                        err <= 1'b0;
                        if (req_on == dom_on) begin
                            done <= 1'b1;
                        end else if (req_on) begin
                            st <= ST_U_PON;
                        end else begin
                            st <= USE_BP ? ST_D_BP : ST_D_SRAM;
                        end
                    end
                end
                ST_U_PON:  st <= ST_U_PON2;
                ST_U_PON2: st <= ST_U_WSTAT;
                ST_U_WSTAT: begin
                    if (stat_a && stat_b) begin
                        st <= ST_U_CKEN;
                    end else if (expired) begin
                        st <= ST_IDLE; err <= 1'b1; tmo <= 1'b1;
                    end
                end
                ST_U_CKEN: st <= ST_U_ISO;
                ST_U_ISO:  st <= ST_U_RST;
                ST_U_RST:  st <= ST_U_SRAM;
                ST_U_SRAM: begin
                    if (HAS_SRAM_WAIT) begin
                        st <= ST_U_WSRAM;
                    end else if (USE_BP) begin
                        st <= ST_U_BP;
                    end else begin
                        st <= ST_IDLE; dom_on <= 1'b1; done <= 1'b1;
                    end
                end
                ST_U_WSRAM: begin
                    if (sram_all_low) begin
                        if (USE_BP) begin
                            st <= ST_U_BP;
                        end else begin
                            st <= ST_IDLE; dom_on <= 1'b1; done <= 1'b1;
                        end
                    end else if (expired) begin
                        st <= ST_IDLE; err <= 1'b1; tmo <= 1'b1;
                    end
                end
                ST_U_BP: begin
                    bp_req <= 1'b0;
                    st     <= ST_U_WBP;
                end
                ST_U_WBP: begin
                    if (!bp_ack) begin
                        st <= ST_IDLE; dom_on <= 1'b1; done <= 1'b1;
                    end else if (expired) begin
                        st <= ST_IDLE; err <= 1'b1; tmo <= 1'b1;
                    end
                end
                ST_D_BP: begin
                    bp_req <= 1'b1;
                    st     <= ST_D_WBP;
                end
                ST_D_WBP: begin
                    if (bp_ack) begin
                        st <= ST_D_SRAM;
                    end else if (expired) begin
                        st <= ST_IDLE; err <= 1'b1; tmo <= 1'b1;
                    end
                end
                ST_D_SRAM: st <= HAS_SRAM_WAIT ? ST_D_WSRAM : ST_D_ISO;
                ST_D_WSRAM: begin
                    if (sram_all_high) begin
                        st <= ST_D_ISO;
                    end else if (expired) begin
                        st <= ST_IDLE; err <= 1'b1; tmo <= 1'b1;
                    end
                end
                ST_D_ISO:  st <= ST_D_RST;
                ST_D_RST:  st <= ST_D_CKD;
                ST_D_CKD:  st <= ST_D_PON;
                ST_D_PON:  st <= ST_D_PON2;
                ST_D_PON2: st <= ST_D_WSTAT;
                ST_D_WSTAT: begin
                    if (!stat_a && !stat_b) begin
                        st <= ST_IDLE; dom_on <= 1'b0; done <= 1'b1;
                    end else if (expired) begin
                        st <= ST_IDLE; err <= 1'b1; tmo <= 1'b1;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/pwr_domain_seq.sv
module pwr_domain_seq
    import pds_pkg::*;
#(
    parameter int               SRAM_W        = 4,
    parameter int               ACK_W         = 4,
    parameter logic [ACK_W-1:0] SRAM_ACK_MASK = '1,
    parameter bit               USE_BUSPROT   = 1'b1,
    parameter int               TMO_CYCLES    = 64,
    localparam int              CTRL_W        = SRAM_LSB + SRAM_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_on,
    input  logic              stat_ack_a,
    input  logic              stat_ack_b,
    input  logic [ACK_W-1:0]  sram_ack,
    input  logic              bp_ack,
    output logic [CTRL_W-1:0] ctrl_word,
    output logic              bp_req,
    output logic              done,
    output logic              err,
    output logic              tmo,
    output logic              busy
);

    seq_st_e st;
    logic    expired;

    pds_fsm #(
        .ACK_W    (ACK_W),
        .ACK_MASK (SRAM_ACK_MASK),
        .USE_BP   (USE_BUSPROT)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_on    (req_on),
        .stat_a    (stat_ack_a),
        .stat_b    (stat_ack_b),
        .sram_ack  (sram_ack),
        .bp_ack    (bp_ack),
        .expired   (expired),
        .st        (st),
        .bp_req    (bp_req),
        .done      (done),
        .tmo       (tmo),
        .err       (err),
        .busy      (busy)
    );

    pds_timeout #(
        .TMO_CYCLES (TMO_CYCLES)
    ) u_tmo (
        .clk     (clk),
        .rst     (rst),
        .run     (is_wait(st)),
        .expired (expired)
    );

    pds_ctrl_word #(
        .SRAM_W (SRAM_W)
    ) u_word (
        .clk  (clk),
        .rst  (rst),
        .op   (op_of(st)),
        .word (ctrl_word)
    );

endmodule

// File: rtl/pds_checker.sv
module pds_checker
    import pds_pkg::*;
#(
    parameter int SRAM_W = 4,
    parameter bit USE_BP = 1'b1,
    localparam int CTRL_W = SRAM_LSB + SRAM_W
) (
    input logic              clk,
    input logic              rst,
    input logic [CTRL_W-1:0] ctrl,
    input logic              stat_a,
    input logic              stat_b,
    input logic              bp_req,
    input logic              done,
    input logic              tmo,
    input logic              err,
    input logic              busy
);

    AST_PON2_AFTER_PON: assert property (@(posedge clk) disable iff (rst)
        $rose(ctrl[BIT_PON2]) |-> $past(ctrl[BIT_PON])); // R2

    AST_CKEN_NEEDS_BOTH_STAT: assert property (@(posedge clk) disable iff (rst)
        $fell(ctrl[BIT_CKD]) |-> $past(stat_a && stat_b, 2)); // R3

    AST_ISO_DROP_ORDER: assert property (@(posedge clk) disable iff (rst)
        $fell(ctrl[BIT_ISO]) |-> (!ctrl[BIT_CKD] && !ctrl[BIT_RST])); // R4

    AST_BP_RELEASE_LAST: assert property (@(posedge clk) disable iff (rst)
        $fell(bp_req) |-> (ctrl[CTRL_W-1:SRAM_LSB] == '0 && ctrl[BIT_RST])); // R6

    AST_ISO_RAISE_AFTER_SRAM: assert property (@(posedge clk) disable iff (rst)
        $rose(ctrl[BIT_ISO]) |-> ((bp_req || !USE_BP) && (&ctrl[CTRL_W-1:SRAM_LSB]))); // R7

    AST_TMO_FLAGS_ERR: assert property (@(posedge clk) disable iff (rst)
        tmo |-> (err && !done)); // R9

    AST_DONE_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy); // R13

endmodule

bind pwr_domain_seq pds_checker #(
    .SRAM_W (SRAM_W),
    .USE_BP (USE_BUSPROT)
) u_chk (
    .clk    (clk),
    .rst    (rst),
    .ctrl   (ctrl_word),
    .stat_a (stat_ack_a),
    .stat_b (stat_ack_b),
    .bp_req (bp_req),
    .done   (done),
    .tmo    (tmo),
    .err    (err),
    .busy   (busy)
);

// File: tb/test_pwr_domain_seq.sv
`timescale 1ns/1ps
module test_pwr_domain_seq;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_on = 1'b0;
    logic        stat_a = 1'b0;
    logic        stat_b = 1'b0;
    logic [3:0]  sram_ack = 4'hF;
    logic        bp_ack = 1'b1;
    logic [11:0] ctrl;
    logic        bp_req, done, err, tmo, busy;

    logic        nm_req_valid = 1'b0;
    logic [11:0] nm_ctrl;
    logic        nm_bp_req, nm_done, nm_err, nm_tmo, nm_busy;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    logic [1:0] fault = 2'd0;

    always #2.5 clk = ~clk;

    pwr_domain_seq i_pwr_domain_seq (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_on(req_on),
        .stat_ack_a(stat_a), .stat_ack_b(stat_b), .sram_ack(sram_ack), .bp_ack(bp_ack),
        .ctrl_word(ctrl), .bp_req(bp_req), .done(done), .err(err), .tmo(tmo), .busy(busy)
    );

    pwr_domain_seq #(.SRAM_ACK_MASK(4'b0000), .USE_BUSPROT(1'b0)) i_pwr_domain_seq_nomask (
        .clk(clk), .rst(rst), .req_valid(nm_req_valid), .req_on(1'b1),
        .stat_ack_a(nm_ctrl[2]), .stat_ack_b(nm_ctrl[3]), .sram_ack(4'hF), .bp_ack(1'b1),
        .ctrl_word(nm_ctrl), .bp_req(nm_bp_req), .done(nm_done), .err(nm_err),
        .tmo(nm_tmo), .busy(nm_busy)
    );

    // Plant model: acknowledges follow the control word with delays
    logic [1:0] pa = '0;
    logic [3:0] pb = '0;
    logic [3:0] ps = 4'hF;
    always @(negedge clk) begin
        pa <= {pa[0], ctrl[2]};
        stat_a <= pa[1];
        pb <= {pb[2:0], ctrl[3]};
        stat_b <= (fault == 2'd1) ? 1'b0 : pb[3];
        ps <= ctrl[11:8];
        sram_ack <= (fault == 2'd2) ? 4'h0 : ps;
        bp_ack <= (fault == 2'd3) ? 1'b1 : bp_req;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    bit got_done, got_tmo, imm_done;
    task automatic run_req(input bit on);
        got_done = 0; got_tmo = 0;
        @(negedge clk); req_valid = 1'b1; req_on = on;
        @(posedge clk); @(negedge clk); req_valid = 1'b0;
        imm_done = done;
        for (int c = 0; c < 400; c++) begin
            if (done || tmo) break;
            @(negedge clk);
        end
        got_done = done; got_tmo = tmo;
    endtask

    logic [11:0] log_w [8];
    int log_n, first_chg, last_chg, bp_evt;
    task automatic log_run(input bit on, input bit poke);
        logic [11:0] prev;
        logic prev_bp;
        log_n = 0; first_chg = -1; last_chg = -1; bp_evt = -1;
        got_done = 0;
        prev = ctrl; prev_bp = bp_req;
        @(negedge clk); req_valid = 1'b1; req_on = on;
        @(posedge clk); @(negedge clk); req_valid = 1'b0;
        for (int c = 0; c < 400; c++) begin
            if (ctrl != prev) begin
                if (log_n < 8) log_w[log_n] = ctrl;
                log_n++;
                if (first_chg < 0) first_chg = c;
                last_chg = c;
                prev = ctrl;
            end
            if (bp_req != prev_bp) begin
                bp_evt = c; prev_bp = bp_req;
            end
            if (poke && c == 3) begin req_valid = 1'b1; req_on = !on; end
            if (poke && c == 4) req_valid = 1'b0;
            if (done || tmo) begin got_done = done; break; end
            @(negedge clk);
        end
    endtask

    // {req_on, fault[1:0], exp_err, exp_bp, exp_ctrl[11:0]}
    localparam logic [16:0] VEC [12] = '{
        {1'b1, 2'd0, 1'b0, 1'b0, 12'h00D},
        {1'b0, 2'd0, 1'b0, 1'b1, 12'hF12},
        {1'b1, 2'd1, 1'b1, 1'b1, 12'hF1E},
        {1'b0, 2'd0, 1'b0, 1'b1, 12'hF1E},
        {1'b1, 2'd0, 1'b0, 1'b0, 12'h00D},
        {1'b0, 2'd2, 1'b1, 1'b1, 12'hF0D},
        {1'b1, 2'd0, 1'b0, 1'b1, 12'hF0D},
        {1'b0, 2'd0, 1'b0, 1'b1, 12'hF12},
        {1'b1, 2'd3, 1'b1, 1'b0, 12'h00D},
        {1'b0, 2'd0, 1'b0, 1'b0, 12'h00D},
        {1'b1, 2'd0, 1'b0, 1'b0, 12'h00D},
        {1'b0, 2'd0, 1'b0, 1'b1, 12'hF12}
    };

    initial begin
        logic [11:0] e;
        logic [11:0] exp_up [6];
        logic [11:0] exp_dn [6];
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check(ctrl == 12'hF12, "R1 ctrl", ctrl, 12'hF12);
        check(bp_req == 1'b1, "R1 bp_req", bp_req, 1);
        check(!done && !tmo, "R1 done/tmo", {done, tmo}, 0);
        check(!err, "R1 err", err, 0);
        check(!busy, "R1 busy", busy, 0);
        check(nm_bp_req == 1'b0, "R1 bp_req without protection", nm_bp_req, 0);

        // Table walk: R9 R10 R12 and end states of R5-R8
        for (int i = 0; i < 12; i++) begin
            fault = VEC[i][15:14];
            repeat (6) @(negedge clk);
            run_req(VEC[i][16]);
            check(ctrl == VEC[i][11:0], $sformatf("R9/R12 vec%0d ctrl", i), ctrl, VEC[i][11:0]);
            check(err == VEC[i][13], $sformatf("R10 vec%0d err", i), err, VEC[i][13]);
            check(bp_req == VEC[i][12], $sformatf("R6/R7 vec%0d bp_req", i), bp_req, VEC[i][12]);
            check(got_tmo == VEC[i][13] && got_done == !VEC[i][13],
                  $sformatf("R9 vec%0d outcome", i), {got_done, got_tmo}, {!VEC[i][13], VEC[i][13]});
        end
        fault = 2'd0;
        repeat (6) @(negedge clk);

        // Expected orders from the requirements
        e = 12'hF12;
        e[2] = 1; exp_up[0] = e; e[3] = 1; exp_up[1] = e; e[4] = 0; exp_up[2] = e;
        e[1] = 0; exp_up[3] = e; e[0] = 1; exp_up[4] = e; e[11:8] = 0; exp_up[5] = e;
        e[11:8] = 4'hF; exp_dn[0] = e; e[1] = 1; exp_dn[1] = e; e[0] = 0; exp_dn[2] = e;
        e[4] = 1; exp_dn[3] = e; e[2] = 0; exp_dn[4] = e; e[3] = 0; exp_dn[5] = e;

        // R2 R4 R5 R6 power-up order
        log_run(1'b1, 1'b0);
        check(log_n == 6, "R2/R4 up step count", log_n, 6);
        for (int k = 0; k < 6; k++)
            check(log_w[k] == exp_up[k], $sformatf("R2/R4 up step %0d", k), log_w[k], exp_up[k]);
        check(bp_evt > last_chg, "R6 bp release after SRAM wake", bp_evt, last_chg);
        check(got_done, "R13 up done", got_done, 1);
        @(negedge clk);
        check(!done, "R13 done one cycle", done, 0);

        // R7 R8 R11 power-down order with an ignored request mid-run
        log_run(1'b0, 1'b1);
        check(log_n == 6, "R8 down step count", log_n, 6);
        for (int k = 0; k < 6; k++)
            check(log_w[k] == exp_dn[k], $sformatf("R7/R8 down step %0d", k), log_w[k], exp_dn[k]);
        check(bp_evt >= 0 && bp_evt < first_chg, "R7 bp raised first", bp_evt, first_chg);
        check(got_done && ctrl == 12'hF12, "R11 ignored request", ctrl, 12'hF12);
        repeat (3) @(negedge clk);
        check(!busy && ctrl == 12'hF12, "R11 no second run", {busy, ctrl}, 12'hF12);

        // R3 status disagreement keeps the sequencer waiting
        fault = 2'd1;
        repeat (6) @(negedge clk);
        @(negedge clk); req_valid = 1'b1; req_on = 1'b1;
        @(posedge clk); @(negedge clk); req_valid = 1'b0;
        repeat (20) @(negedge clk);
        check(ctrl[4] == 1'b1, "R3 clock still disabled", ctrl[4], 1);
        check(busy == 1'b1, "R3 still waiting", busy, 1);
        check(stat_a != stat_b, "R3 acks disagree", {stat_a, stat_b}, 2);
        fault = 2'd0;
        for (int c = 0; c < 200; c++) begin
            if (done || tmo) break;
            @(negedge clk);
        end
        check(done && ctrl == 12'h00D, "R3 completes once acks agree", ctrl, 12'h00D);

        // R12 immediate done for same-state request
        repeat (3) @(negedge clk);
        run_req(1'b1);
        check(imm_done, "R12 done next cycle", imm_done, 1);
        check(ctrl == 12'h00D, "R12 ctrl unchanged", ctrl, 12'h00D);

        // R5 R6 empty mask and no bus protection
        @(negedge clk); nm_req_valid = 1'b1;
        @(posedge clk); @(negedge clk); nm_req_valid = 1'b0;
        for (int c = 0; c < 30; c++) begin
            if (nm_done || nm_tmo) break;
            @(negedge clk);
        end
        check(nm_done && !nm_err, "R5 SRAM wait skipped", {nm_done, nm_err}, 2);
        check(nm_ctrl == 12'h00D, "R5 ctrl on", nm_ctrl, 12'h00D);
        check(nm_bp_req == 1'b0, "R6 no protection", nm_bp_req, 0);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule